// File: doc/BRIEF.md
# Burst Column Sequencer

This block produces the column address for each beat of one read or write burst to a synchronous DRAM. A start strobe captures a start column, a 3-bit burst-length code and a wrap-order bit. The first beat appears on the next cycle. Each advance strobe then moves the sequence on by one beat. Fixed bursts of 1, 2, 4 or 8 beats end by themselves, and the last beat is flagged. A full-page burst walks the whole row and runs until a stop strobe ends it.

The address wraps inside an aligned block whose size is the burst length. The column bits above that block never change during a fixed burst. Two orders are offered inside the block. Sequential order counts upward from the start offset. Interleaved order combines the start offset with the beat number by exclusive-or. A configuration the sequencer cannot honour is flagged and then run as a single-beat burst.

Top module: `burst_colgen`

## Requirements
- R1: After reset, `valid_o`, `last_o` and `cfg_err_o` are low.
- R2: The length code `len_code_i` is decoded as follows: 3'b000 gives 1 beat, 3'b001 gives 2, 3'b010 gives 4, 3'b011 gives 8, and 3'b111 gives a full-page burst. A fixed burst offers exactly that many beats while `valid_o` is high.
- R3: With `ilv_i`=0, beat k of a fixed burst of length BL has low bits equal to (start mod BL + k) mod BL. For example, BL=4 started at 2 gives 2,3,0,1.
- R4: With `ilv_i`=1, beat k of a fixed burst has low bits equal to (start mod BL) XOR k. For example, BL=8 started at 5 gives 5,4,7,6,1,0,3,2.
- R5: During a fixed burst, the column bits above the aligned BL-sized block keep the values of the start column.
- R6: A full-page burst (code 3'b111, `ilv_i`=0) gives column (start + k) mod 2^COL_W on beat k, wrapping from the top column to 0. It never asserts `last_o`.
- R7: A `stop_i` pulse without `start_i` during a burst drops `valid_o` on the next cycle.
- R8: `start_i` takes priority over `stop_i` and `advance_i`. A start during a burst restarts the sequence at the new column with the new configuration, and beat 0 appears on the next cycle.
- R9: A reserved length code (3'b100, 3'b101, 3'b110), or full page with `ilv_i`=1, sets `cfg_err_o` for that burst. The burst then runs as BL=1, with a single beat at the start column.
- R10: `last_o` is high exactly on the final beat of a fixed burst. An advance on that beat drops `valid_o` on the next cycle.
- R11: With `advance_i` low, the column holds. While no burst is active, `advance_i` has no effect and `valid_o` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a burst at `start_col_i` |
| advance_i | input | 1 | Step to the next beat |
| stop_i | input | 1 | End the current burst |
| start_col_i | input | COL_W | First column of the burst |
| len_code_i | input | 3 | Burst-length code |
| ilv_i | input | 1 | 0 selects sequential order, 1 selects interleaved order |
| col_o | output | COL_W | Column for the current beat |
| valid_o | output | 1 | A beat is being presented |
| last_o | output | 1 | Final beat of a fixed burst |
| cfg_err_o | output | 1 | The captured configuration was illegal |

## Verification
The assertions assume that `start_col_i`, `len_code_i` and `ilv_i` are meaningful only in the cycle that `start_i` is high. They also assume that strobes are sampled on clean edges, so every check is written in terms of the configuration captured at the start. The stimulus drives each strobe for whole cycles, a short time after the rising edge. It changes the configuration only alongside a start. Across the sweep, every length code and both orders are used with start columns spread over the whole row. Full-page bursts are ended only with `stop_i`, and fixed bursts are ended either by advancing past the last beat or by stopping early.

// File: rtl/colgen_pkg.sv
package colgen_pkg;

  localparam logic [2:0] LEN_CODE_PAGE = 3'b111;

  typedef struct packed {
    logic full;
    logic ilv;
    logic err;
  } burst_mode_t;

  function automatic logic code_is_fixed(input logic [2:0] code);
    return code[2] == 1'b0;
  endfunction

endpackage

// File: rtl/colgen_decode.sv
module colgen_decode
  import colgen_pkg::*;
#(
  parameter int COL_W = 9
) (
  input  logic [2:0]       len_code_i,
  input  logic             ilv_i,
  output burst_mode_t      mode_o,
  output logic [COL_W-1:0] mask_o
);

  function automatic logic [COL_W-1:0] fixed_mask(input logic [1:0] lg);
    logic [COL_W-1:0] m;
    m = '0;
    for (int i = 0; i < COL_W; i++) m[i] = (i < int'(lg));
    return m;
  endfunction

  logic fixed_ok, page_ok;

  always_comb begin
    fixed_ok    = code_is_fixed(len_code_i);
    page_ok     = (len_code_i == LEN_CODE_PAGE) && !ilv_i;
    mode_o.full = page_ok;
    mode_o.err  = !(fixed_ok || page_ok);
    mode_o.ilv  = ilv_i && fixed_ok;
    if (page_ok)       mask_o = '1;
    else if (fixed_ok) mask_o = fixed_mask(len_code_i[1:0]);
    else               mask_o = '0;
  end

endmodule

// File: rtl/colgen_addr.sv
module colgen_addr #(
  parameter int COL_W = 9
) (
  input  logic [COL_W-1:0] base_i,
  input  logic [COL_W-1:0] beat_i,
  input  logic [COL_W-1:0] mask_i,
  input  logic             ilv_i,
  output logic [COL_W-1:0] col_o
);

  function automatic logic [COL_W-1:0] beat_offset(
    input logic [COL_W-1:0] b, input logic [COL_W-1:0] k, input logic x);
    return x ? (b ^ k) : (b + k);
  endfunction

  logic [COL_W-1:0] off;
  assign off = beat_offset(base_i, beat_i, ilv_i);

  for (genvar i = 0; i < COL_W; i++) begin : g_bit
    assign col_o[i] = mask_i[i] ? off[i] : base_i[i];
  end

endmodule

// File: rtl/burst_colgen.sv
module burst_colgen
  import colgen_pkg::*;
#(
  parameter int COL_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             advance_i,
  input  logic             stop_i,
  input  logic [COL_W-1:0] start_col_i,
  input  logic [2:0]       len_code_i,
  input  logic             ilv_i,
  output logic [COL_W-1:0] col_o,
  output logic             valid_o,
  output logic             last_o,
  output logic             cfg_err_o
);

  burst_mode_t      dec_mode, mode_q;
  logic [COL_W-1:0] dec_mask, mask_q, base_q, beat_q;
  logic             valid_q;
  logic             at_last;

  colgen_decode #(.COL_W(COL_W)) u_decode (
    .len_code_i(len_code_i),
    .ilv_i     (ilv_i),
    .mode_o    (dec_mode),
    .mask_o    (dec_mask)
  );

  colgen_addr #(.COL_W(COL_W)) u_addr (
    .base_i(base_q),
    .beat_i(beat_q),
    .mask_i(mask_q),
    .ilv_i (mode_q.ilv),
    .col_o (col_o)
  );

  assign at_last = !mode_q.full && (beat_q == mask_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      base_q  <= '0;
      beat_q  <= '0;
      mask_q  <= '0;
      mode_q  <= '0;
    end else if (start_i) begin
      valid_q <= 1'b1;
      base_q  <= start_col_i;
      beat_q  <= '0;
      mask_q  <= dec_mask;
      mode_q  <= dec_mode;
    end else if (valid_q) begin
      if (stop_i)                   valid_q <= 1'b0;
      else if (advance_i && at_last) valid_q <= 1'b0;
      else if (advance_i)           beat_q  <= beat_q + 1'b1;
    end
  end

  assign valid_o   = valid_q;
  assign last_o    = valid_q && at_last;
  assign cfg_err_o = mode_q.err;

  assert_last_needs_valid_R10: assert property (@(posedge clk) disable iff (!rst_n)
    last_o |-> valid_o);
  assert_page_no_last_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && mode_q.full) |-> !last_o);
  assert_beat_in_block_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && !mode_q.full) |-> ((beat_q & ~mask_q) == '0));
  assert_upper_fixed_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && $past(valid_o) && !$past(start_i) && !mode_q.full)
      |-> ((col_o & ~mask_q) == ($past(col_o) & ~mask_q)));
  assert_stop_ends_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_i && !start_i) |=> !valid_o);
  assert_start_beat0_R8: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> (valid_o && col_o == $past(start_col_i)));
  assert_hold_col_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && !advance_i && !start_i && !stop_i) |=> (valid_o && $stable(col_o)));
  assert_err_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && cfg_err_o) |-> last_o);

endmodule

// File: tb/tb_burst_colgen.sv
`timescale 1ns/1ps
module tb_burst_colgen;
  localparam int COL_W = 9;
  localparam int ROW = 1 << COL_W;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 1'b0, advance_i = 1'b0, stop_i = 1'b0, ilv_i = 1'b0;
  logic [COL_W-1:0] start_col_i = '0;
  logic [2:0] len_code_i = '0;
  logic [COL_W-1:0] col_o;
  logic valid_o, last_o, cfg_err_o;
  int nchk = 0, nfail = 0;

  always #4 clk = ~clk;

  burst_colgen #(.COL_W(COL_W)) dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .advance_i(advance_i),
    .stop_i(stop_i), .start_col_i(start_col_i), .len_code_i(len_code_i),
    .ilv_i(ilv_i), .col_o(col_o), .valid_o(valid_o), .last_o(last_o),
    .cfg_err_o(cfg_err_o)
  );

  task automatic check(string req, string what, int act, int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic bit is_page(int code, bit x);
    return code == 7 && !x;
  endfunction

  function automatic bit is_err(int code, bit x);
    return !(code <= 3 || is_page(code, x));
  endfunction

  function automatic int burst_len(int code, bit x);
    if (is_err(code, x)) return 1;
    return 1 << code;
  endfunction

  function automatic int exp_col(int base, int code, bit x, int k);
    int bl, blk, off;
    if (is_page(code, x)) return (base + k) % ROW;
    bl  = burst_len(code, x);
    off = base % bl;
    blk = base - off;
    if (x && !is_err(code, x)) return blk + (off ^ k);
    return blk + (off + k) % bl;
  endfunction

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic do_start(int sc, int code, bit x);
    start_i = 1'b1; start_col_i = sc[COL_W-1:0]; len_code_i = code[2:0]; ilv_i = x;
    tick();
    start_i = 1'b0;
  endtask

  task automatic run_burst(int sc, int code, bit x, int page_beats);
    string req;
    int n, bl;
    bit pg;
    pg  = is_page(code, x);
    bl  = burst_len(code, x);
    n   = pg ? page_beats : bl;
    req = pg ? "R6" : is_err(code, x) ? "R9" : x ? "R4" : "R3";
    advance_i = 1'b0;
    do_start(sc, code, x);
    check(is_err(code, x) ? "R9" : "R2", "cfg_err", int'(cfg_err_o), int'(is_err(code, x)));
    for (int k = 0; k < n; k++) begin
      check("R2", "valid", int'(valid_o), 1);
      check(req, "col", int'(col_o), exp_col(sc, code, x, k));
      check(pg ? "R6" : "R10", "last", int'(last_o), int'(!pg && k == bl - 1));
      if (!pg) check("R5", "upper", int'(col_o) / bl, sc / bl);
      advance_i = 1'b1;
      tick();
    end
    advance_i = 1'b0;
    if (pg) begin
      check("R6", "page still valid", int'(valid_o), 1);
      stop_i = 1'b1;
      tick();
      stop_i = 1'b0;
      check("R7", "valid after stop", int'(valid_o), 0);
    end else begin
      check("R10", "valid after last", int'(valid_o), 0);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    #1;
    check("R1", "valid in reset", int'(valid_o), 0);
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    check("R1", "valid", int'(valid_o), 0);
    check("R1", "last", int'(last_o), 0);
    check("R1", "cfg_err", int'(cfg_err_o), 0);

    // R4 and R3 worked examples
    run_burst(5, 3, 1'b1, 0);
    run_burst(2, 2, 1'b0, 0);

    // Sweep of codes, orders and start columns
    for (int code = 0; code < 8; code++)
      for (int x = 0; x < 2; x++)
        for (int sc = 0; sc < ROW; sc += 5)
          run_burst(sc, code, x[0], 12);

    // R6 wrap across the top of the row
    run_burst(ROW - 7, 7, 1'b0, 20);

    // R11 hold with advance low, and advance while idle
    do_start(10, 3, 1'b0);
    check("R11", "col beat0", int'(col_o), 10);
    tick();
    check("R11", "col held", int'(col_o), 10);
    check("R11", "valid held", int'(valid_o), 1);
    advance_i = 1'b1;
    tick();
    check("R11", "col after advance", int'(col_o), 11);
    stop_i = 1'b1; advance_i = 1'b0;
    tick();
    stop_i = 1'b0;
    check("R7", "fixed stopped early", int'(valid_o), 0);
    advance_i = 1'b1;
    tick();
    tick();
    advance_i = 1'b0;
    check("R11", "idle advance ignored", int'(valid_o), 0);
    check("R11", "idle last", int'(last_o), 0);

    // R8 restart during a burst, start beats advance and stop
    do_start(3, 3, 1'b0);
    advance_i = 1'b1;
    tick();
    tick();
    check("R8", "pre-restart col", int'(col_o), 5);
    start_i = 1'b1; stop_i = 1'b1; start_col_i = 101; len_code_i = 3'b010; ilv_i = 1'b1;
    tick();
    start_i = 1'b0; stop_i = 1'b0;
    check("R8", "restart valid", int'(valid_o), 1);
    check("R8", "restart beat0", int'(col_o), 101);
    tick();
    check("R8", "restart beat1", int'(col_o), 100);
    tick();
    check("R8", "restart beat2", int'(col_o), 103);
    check("R8", "restart not last", int'(last_o), 0);
    tick();
    check("R8", "restart beat3", int'(col_o), 102);
    check("R8", "restart last", int'(last_o), 1);
    tick();
    advance_i = 1'b0;
    check("R10", "restart done", int'(valid_o), 0);

    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

endmodule